// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that keeps its data bus busy on every clock, whatever mix of reads and writes the host issues. A read returns its word combinationally in the same cycle in which its address was captured (flow-through). A write captures its address and byte enables at one edge and its data at the next enabled edge (late write). Because the write data phase lands exactly where a read would have put its output, reads and writes can alternate on consecutive cycles with no idle slot between them.

An operation is started by capturing an external address. Further beats are produced by a two-bit burst counter that steps through four words in either linear or interleaved order. A clock-enable input freezes the whole block. Per-byte active-low enables select which lanes of a write are stored. The bidirectional data bus is split into a data-in port, a data-out port and an output-enable flag. A small parameterised array stands in for the full memory.

Top module: `nt_flow_sram`

## Requirements
- R1: A new operation starts at a rising edge only when cke_n is low, adv is low, cs1_n is low, cs2 is high and cs3_n is low; the address on addr is captured at that edge. After reset the block is deselected and q_oe is 0.
- R2: At an edge where cke_n is high, every synchronous input (addr, selects, adv, we_n, bw_n, d_in) is ignored and all internal state, including burst position and a pending write, holds its value.
- R3: An operation started with we_n high is a read: q_out shows the word at the current beat address in the same cycle. q_oe is 1 only in a read cycle while oe_n is low. With oe_n high (a dummy read), q_oe is 0 but the burst still advances.
- R4: An operation started with we_n low is a write: address and bw_n are captured at the start edge, and d_in is stored at the next edge where cke_n is low. Lane i occupies bits [i*LANE_W +: LANE_W] and is written only when bw_n[i] is 0. q_oe stays 0 during write cycles.
- R5: At an enabled edge with adv high, the current operation continues at the next burst address: a read stays a read, a write stays a write (bw_n sampled again for the new beat), a deselect stays a deselect.
- R6: With lbo = 0 (linear order), the two address LSBs of beat k are (start LSBs + k) mod 4; the upper address bits stay fixed.
- R7: With lbo = 1 (interleaved order), the two address LSBs of beat k are start LSBs XOR k; the upper address bits stay fixed.
- R8: The fifth beat of a burst returns to the start address.
- R9: A write beat with all bw_n bits high stores nothing, yet the burst still advances to the next address.
- R10: An enabled edge with adv low and any chip select inactive deselects the block; q_oe is 0 and stays 0 on following adv-high edges.
- R11: A read started at the edge that takes the late-write data for the same address returns the newly written word.
- R12: Reads and writes may be started on consecutive edges with no idle cycle, and every read still returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | Low loads a new address, high advances the burst |
| we_n | input | 1 | Low starts a write, high a read |
| bw_n | input | LANES | Active-low byte lane write enables |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| lbo | input | 1 | Burst order: 0 linear, 1 interleaved |
| d_in | input | LANES*LANE_W | Write data bus input |
| q_out | output | LANES*LANE_W | Read data bus output |
| q_oe | output | 1 | High while the block drives the data bus |

## Verification
The array is first filled with back-to-back single-word writes, so the late-write pipeline is used on every edge from the start. Four-beat reads are then taken from each of the four start offsets under both burst orders, continuing to a fifth beat and with random clock-enable stalls inserted, which separates linear from interleaved stepping, shows the wrap to the start word, and shows that a stall neither advances nor corrupts a burst. Write bursts mix full, partial and all-disabled lane masks, with a stall carrying junk data, and are read back so that lane placement, write abort and late-data timing are each told apart. Dummy reads, the three ways of deselecting, read-after-write on the same address and strict read/write alternation cover output gating and the no-turnaround claim.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;

   // operation held by the block between edges
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // low two address bits for beat idx of a burst that began at first
   function automatic logic [1:0] beat_lsb(input logic [1:0] first,
                                           input logic [1:0] idx,
                                           input logic       xor_order);
      logic [1:0] r;
      if (xor_order) r = first ^ idx;
      else           r = first + idx;
      return r;
   endfunction

endpackage

// File: rtl/ntsram_cmd_dec.sv
module ntsram_cmd_dec (
   input  logic cke_n,
   input  logic cs1_n,
   input  logic cs2,
   input  logic cs3_n,
   input  logic adv,
   input  logic we_n,
   output logic edge_en,
   output logic load,
   output logic sel,
   output logic start_rd,
   output logic start_wr
);
   always_comb begin
      edge_en  = ~cke_n;
      sel      = ~cs1_n & cs2 & ~cs3_n;
      load     = edge_en & ~adv;
      start_rd = load & sel & we_n;
      start_wr = load & sel & ~we_n;
   end
endmodule

// File: rtl/ntsram_burst.sv
module ntsram_burst #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_en,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              lbo,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr
);
   import ntsram_pkg::*;

   localparam int HI_W = ADDR_W - 2;

   logic [HI_W-1:0] hi_q;
   logic [1:0]      first_q;
   logic [1:0]      beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         first_q <= '0;
         beat_q  <= '0;
      end else if (edge_en) begin
         if (load) begin
            hi_q    <= ld_addr[ADDR_W-1:2];
            first_q <= ld_addr[1:0];
            beat_q  <= 2'd0;
         end else begin
            beat_q  <= beat_q + 2'd1;
         end
      end
   end

   always_comb begin
      cur_addr = {hi_q, beat_lsb(first_q, beat_q, lbo)};
      if (load) nxt_addr = ld_addr;
      else      nxt_addr = {hi_q, beat_lsb(first_q, beat_q + 2'd1, lbo)};
   end
endmodule

// File: rtl/ntsram_lanes.sv
module ntsram_lanes #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && lane_we[g])
            mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
   end
endmodule

// File: rtl/nt_flow_sram.sv
module nt_flow_sram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    adv,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    oe_n,
   input  logic                    lbo,
   input  logic [LANES*LANE_W-1:0] d_in,
   output logic [LANES*LANE_W-1:0] q_out,
   output logic                    q_oe
);
   import ntsram_pkg::*;

   localparam int DW = LANES * LANE_W;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("nt_flow_sram: ADDR_W must be at least 3");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("nt_flow_sram: LANES and LANE_W must be positive");
   end

   logic edge_en, load, sel, start_rd, start_wr;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;

   ntsram_cmd_dec u_dec (
      .cke_n   (cke_n),
      .cs1_n   (cs1_n),
      .cs2     (cs2),
      .cs3_n   (cs3_n),
      .adv     (adv),
      .we_n    (we_n),
      .edge_en (edge_en),
      .load    (load),
      .sel     (sel),
      .start_rd(start_rd),
      .start_wr(start_wr)
   );

   ntsram_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_en (edge_en),
      .load    (load),
      .ld_addr (addr),
      .lbo     (lbo),
      .cur_addr(cur_addr),
      .nxt_addr(nxt_addr)
   );

   op_e               op_q, op_d;
   logic              wp_valid_q;
   logic [ADDR_W-1:0] wp_addr_q;
   logic [LANES-1:0]  wp_bw_n_q;

   // next operation: a load picks a fresh one, an advance keeps the old one
   always_comb begin
      op_d = op_q;
      if (load) begin
         if (start_rd)      op_d = OP_READ;
         else if (start_wr) op_d = OP_WRITE;
         else               op_d = OP_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q       <= OP_IDLE;
         wp_valid_q <= 1'b0;
         wp_addr_q  <= '0;
         wp_bw_n_q  <= '1;
      end else if (edge_en) begin
         op_q       <= op_d;
         wp_valid_q <= (op_d == OP_WRITE);
         wp_addr_q  <= nxt_addr;
         wp_bw_n_q  <= bw_n;
      end
   end

   logic          commit;
   logic [DW-1:0] rd_word;

   assign commit = edge_en & wp_valid_q;

   ntsram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .clk    (clk),
      .wr_en  (commit),
      .wr_addr(wp_addr_q),
      .lane_we(~wp_bw_n_q),
      .wr_data(d_in),
      .rd_addr(cur_addr),
      .rd_data(rd_word)
   );

   assign q_out = rd_word;
   assign q_oe  = (op_q == OP_READ) & ~oe_n;
endmodule

// File: rtl/ntsram_chk.sv
module ntsram_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cke_n,
   input logic                    cs1_n,
   input logic                    cs2,
   input logic                    cs3_n,
   input logic                    adv,
   input logic                    we_n,
   input logic                    oe_n,
   input logic                    lbo,
   input logic [LANES*LANE_W-1:0] q_out,
   input logic                    q_oe
);
   logic sel_now;
   assign sel_now = !cs1_n && cs2 && !cs3_n;

   // R10: a load with any select inactive leaves the bus released
   a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv && !sel_now) |=> !q_oe);

   // R4: a write start never drives the bus in its cycle
   a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv && sel_now && !we_n) |=> !q_oe);

   // R3: a read start drives the bus exactly when oe_n is low
   a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv && sel_now && we_n) |=> (q_oe == !oe_n));

   // R5: an advance of a driving read keeps reading
   a_r5_read_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv && q_oe) |=> (q_oe == !oe_n));

   // R2: a suspended edge changes no read data
   a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_n ##1 $stable(lbo)) |-> $stable(q_out));

   // R2: a suspended edge changes no bus drive
   a_r2_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_n ##1 $stable(oe_n)) |-> $stable(q_oe));
endmodule

bind nt_flow_sram ntsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .cke_n(cke_n),
   .cs1_n(cs1_n),
   .cs2  (cs2),
   .cs3_n(cs3_n),
   .adv  (adv),
   .we_n (we_n),
   .oe_n (oe_n),
   .lbo  (lbo),
   .q_out(q_out),
   .q_oe (q_oe)
);

// File: tb/nt_flow_sram_tb.sv
module nt_flow_sram_tb;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
   logic          adv = 1'b0, we_n = 1'b1, oe_n = 1'b0, lbo = 1'b0;
   logic [NL-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d_in = '0;
   logic [DW-1:0] q_out;
   logic          q_oe;

   always #10 clk = ~clk;

   nt_flow_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .oe_n(oe_n), .lbo(lbo), .d_in(d_in), .q_out(q_out), .q_oe(q_oe)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DW-1:0] ref_mem [1 << AW];
   logic          pv = 1'b0, nv = 1'b0;
   logic [AW-1:0] pa = '0, na = '0;
   logic [NL-1:0] pb = '1, nb = '1;

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      logic [DW-1:0] v;
      v = DW'(a) * DW'(40503) + DW'(salt) * DW'(7919);
      return v ^ 36'h5A5A5A5A5;
   endfunction

   function automatic logic [AW-1:0] bexp(input logic [AW-1:0] a, input int b, input bit il);
      logic [1:0] k;
      k = 2'(b);
      return {a[AW-1:2], il ? (a[1:0] ^ k) : (a[1:0] + k)};
   endfunction

   // one clock: reference commits late data exactly as the requirements say
   task automatic tick();
      if (!cke_n && pv)
         for (int l = 0; l < NL; l++)
            if (!pb[l]) ref_mem[pa][l*LW +: LW] = d_in[l*LW +: LW];
      if (!cke_n) begin
         pv = nv; pa = na; pb = nb;
      end
      nv = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sel_on();
      cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
   endtask

   task automatic cmd_load(input bit wr, input logic [AW-1:0] a,
                           input logic [NL-1:0] bw, input logic [DW-1:0] d);
      cke_n = 1'b0; adv = 1'b0; sel_on(); we_n = ~wr; addr = a; bw_n = bw; d_in = d;
      if (wr) begin nv = 1'b1; na = a; nb = bw; end
      tick();
   endtask

   task automatic cmd_cont(input bit wr, input logic [AW-1:0] ea,
                           input logic [NL-1:0] bw, input logic [DW-1:0] d);
      cke_n = 1'b0; adv = 1'b1; addr = AW'($urandom); we_n = 1'($urandom);
      bw_n = bw; d_in = d;
      if (wr) begin nv = 1'b1; na = ea; nb = bw; end
      tick();
   endtask

   task automatic cmd_stall();
      cke_n = 1'b1; adv = 1'($urandom); we_n = 1'($urandom); addr = AW'($urandom);
      bw_n = NL'($urandom); d_in = DW'({$urandom, $urandom});
      cs1_n = 1'($urandom);
      tick();
      sel_on();
   endtask

   task automatic cmd_desel(input int kind, input logic [DW-1:0] d);
      cke_n = 1'b0; adv = 1'b0; sel_on(); d_in = d; we_n = 1'($urandom);
      case (kind)
         0: cs1_n = 1'b1;
         1: cs2   = 1'b0;
         default: cs3_n = 1'b1;
      endcase
      tick();
      sel_on();
   endtask

   task automatic chk_read(input string rq, input logic [AW-1:0] ea);
      checks++;
      if (q_oe !== 1'b1 || q_out !== ref_mem[ea]) begin
         fails++;
         $display("FAIL %s addr=%0d: q_oe=%b q_out=%h expected q_oe=1 q_out=%h",
                  rq, ea, q_oe, q_out, ref_mem[ea]);
      end
   endtask

   task automatic chk_bit(input string rq, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%b expected=%b", rq, act, exp);
      end
   endtask

   task automatic chk_word(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [NL-1:0] bws [4];
      bws[0] = 4'h0; bws[1] = 4'hA; bws[2] = 4'hF; bws[3] = 4'h5;
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk_bit("R1 reset deselected", q_oe, 1'b0);

      // R4 R12: fill every word with back-to-back single writes
      for (int a = 0; a < (1 << AW); a++)
         cmd_load(1'b1, AW'(a), '0, (a == 0) ? '0 : pat(a - 1, 0));
      chk_bit("R4 write cycle bus released", q_oe, 1'b0);
      cmd_desel(0, pat((1 << AW) - 1, 0));

      // R6 R7 R8 R2: read bursts from every start offset in both orders
      for (int il = 0; il < 2; il++) begin
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a;
            a = AW'((8 * s + 4 * il + 16) & ((1 << AW) - 4)) | AW'(s);
            lbo = il[0];
            cmd_load(1'b0, a, '1, '0);
            chk_read(il ? "R7 interleaved beat0" : "R6 linear beat0", bexp(a, 0, il[0]));
            for (int b = 1; b <= 4; b++) begin
               if ($urandom % 3 == 0) begin
                  cmd_stall();
                  chk_read("R2 stall holds read beat", bexp(a, b - 1, il[0]));
               end
               cmd_cont(1'b0, '0, '1, '0);
               if (b == 4) chk_read("R8 wrap to start", bexp(a, b, il[0]));
               else chk_read(il ? "R7 interleaved beat" : "R6 linear beat", bexp(a, b, il[0]));
            end
            cmd_desel(2, '0);
         end
      end

      // R4 R9 R5 R2: write bursts with mixed lane masks, then read back
      for (int il = 0; il < 2; il++) begin
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] old_abort;
            a = AW'(32 + 8 * il + 4 * (s % 2)) | AW'(s);
            lbo = il[0];
            old_abort = ref_mem[bexp(a, 2, il[0])];
            cmd_load(1'b1, a, bws[0], DW'({$urandom, $urandom}));
            for (int b = 1; b <= 3; b++) begin
               if (b == 2) cmd_stall();
               cmd_cont(1'b1, bexp(a, b, il[0]), bws[b], pat(a + b - 1, 5 + s));
            end
            cmd_desel(1, pat(a + 3, 5 + s));
            cmd_load(1'b0, a, '1, '0);
            chk_read("R4 lane write beat0", bexp(a, 0, il[0]));
            cmd_cont(1'b0, '0, '1, '0);
            chk_read("R4 partial lanes beat1", bexp(a, 1, il[0]));
            cmd_cont(1'b0, '0, '1, '0);
            chk_word("R9 abort stores nothing", q_out, old_abort);
            cmd_cont(1'b0, '0, '1, '0);
            chk_read("R9 burst advanced past abort", bexp(a, 3, il[0]));
            cmd_desel(0, '0);
         end
      end

      // R3: dummy read advances burst without driving
      lbo = 1'b0;
      oe_n = 1'b1;
      cmd_load(1'b0, 6'd20, '1, '0);
      chk_bit("R3 dummy read no drive", q_oe, 1'b0);
      cmd_cont(1'b0, '0, '1, '0);
      chk_bit("R3 dummy read beat1 no drive", q_oe, 1'b0);
      oe_n = 1'b0;
      #1;
      chk_read("R3 oe low shows advanced beat", bexp(6'd20, 1, 1'b0));
      cmd_cont(1'b0, '0, '1, '0);
      chk_read("R3 read same cycle", bexp(6'd20, 2, 1'b0));

      // R10: each select deselects, continue keeps it deselected
      for (int k = 0; k < 3; k++) begin
         cmd_load(1'b0, AW'(4 * k), '1, '0);
         chk_read("R1 read start", AW'(4 * k));
         cmd_desel(k, '0);
         chk_bit("R10 deselect releases bus", q_oe, 1'b0);
         cmd_cont(1'b0, '0, '1, '0);
         chk_bit("R10 continued deselect", q_oe, 1'b0);
      end

      // R11: read at the edge that takes the late data
      cmd_load(1'b1, 6'd33, '0, '0);
      cmd_load(1'b0, 6'd33, '1, 36'h9_C3A5_F00D);
      chk_word("R11 read sees new word", q_out, 36'h9_C3A5_F00D);
      chk_bit("R11 drive", q_oe, 1'b1);

      // R12: strict read/write alternation
      for (int i = 0; i < 8; i++) begin
         logic [AW-1:0] w;
         w = AW'(7 * i + 3);
         cmd_load(1'b1, w, NL'(i), '0);
         chk_bit("R12 write slot released", q_oe, 1'b0);
         cmd_load(1'b0, w, '1, pat(i, 99));
         chk_read("R12 alternating read", w);
      end
      cmd_desel(0, '0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule